// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block decides which input of an eight-input successive-approximation converter is converted next. It keeps a 3-bit current-address register, an 8-bit channel-select mask and a 2-bit operating mode. It also has an 8-bit control port that carries an enable, an address-load enable, a channel number and a high/low data select. The block issues one-cycle start pulses to the converter. It waits for the converter's done input, and it emits a result strobe carrying the channel number so that external data registers can capture each result.

The mode selects the behaviour. Mode 1 converts one channel for each enabling control write and raises the interrupt flag after every conversion. Mode 2 scans the selected channels over and over and raises the interrupt flag at the end of each full pass. Mode 3 scans the same way but never raises the interrupt flag. Mode 0 converts nothing.

The first channel converted is always the one in the address register, even when its mask bit is clear. After that, the search climbs in ascending order and wraps from 7 to 0. Flags report a conversion in progress, completion of every selected channel, and a pending interrupt.

Top module: `adc_scan_seq`

## Requirements
- R1: A control write with bit 4 set loads the current address from bits 3:1. With bit 4 clear the address is unchanged. Every control write stores bit 0 as `hl_sel`.
- R2: Bit 7 of a control write is the enable. In modes 2 and 3, an enable held high with a nonzero mask starts the channel in the current address with a one-cycle `conv_start` pulse, and `conv_chan` gives that channel. No conversion starts while the enable is low.
- R3: Clearing the enable while a conversion runs lets that conversion complete with its result strobe, and no later conversion starts.
- R4: On completion the current address becomes the next channel above the converted one whose mask bit is set, wrapping from 7 to 0. A control load in the same cycle wins.
- R5: A loaded channel whose mask bit is clear is converted once, then never again in the scan that follows.
- R6: `busy` rises together with `conv_start` and falls in the cycle of the result strobe. It stays low for at least one cycle between two conversions.
- R7: `all_done` sets when every masked channel has completed since the last pass or clear. A data read clears it, but a set in the same cycle wins. A mode or mask write clears it with top priority.
- R8: In mode 1 each control write with bit 7 set converts exactly one channel. `all_done` sets only after every masked channel has been converted by its own write.
- R9: `irq` sets on every completion in mode 1, when `all_done` sets in mode 2, and never in mode 3. A status or data read clears it, but a set in the same cycle wins. A mode or mask write clears it with top priority.
- R10: Every completion gives a one-cycle `res_we` pulse, with `res_chan` equal to the channel just converted.
- R11: A scanning mode with an all-zero mask performs no conversions. Mode 0 performs none with any mask.
- R12: After reset all outputs are zero and the current address is channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control word: bit 7 enable, bit 4 load, bits 3:1 channel, bit 0 high/low |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode: 0 off, 1 single, 2 scan with interrupt, 3 scan without interrupt |
| mask_we | input | 1 | Channel-select mask write strobe |
| mask_wdata | input | 8 | Mask, bit n selects channel n |
| data_rd | input | 1 | Data register read event |
| status_rd | input | 1 | Status read event |
| conv_done | input | 1 | Converter finished the current channel |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_chan | output | 3 | Channel being converted |
| busy | output | 1 | Conversion in progress |
| cur_addr | output | 3 | Current address register |
| hl_sel | output | 1 | Stored high/low select |
| all_done | output | 1 | Every masked channel converted |
| irq | output | 1 | Interrupt flag |
| res_we | output | 1 | Result capture strobe |
| res_chan | output | 3 | Channel of the captured result |

## Verification
The assertions check several handshake rules on every cycle. A start pulse always coincides with `busy`. `busy` falls only together with a result strobe, and a strobe never coincides with a start. A start never occurs unless the enable was high. The interrupt never rises in mode 3, and `all_done` is never seen with an empty mask. Other behaviours can only be shown by the bench's scenarios against its reference model: the ascending and wrapping order, the single conversion of an unmasked loaded channel, the finish-then-stop response to clearing the enable, one conversion per write in mode 1, and the clear and set priorities of the flags.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int CH_W = 3;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'd0,
        MODE_SINGLE   = 2'd1,
        MODE_SCAN_IRQ = 2'd2,
        MODE_SCAN     = 2'd3
    } scan_mode_e;

    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_LOAD_BIT = 4;
    localparam int CTL_CH_LSB   = 1;
    localparam int CTL_HL_BIT   = 0;

    typedef struct packed {
        logic            en;
        logic            load;
        logic [CH_W-1:0] chan;
        logic            hl;
    } ctl_word_t;

    function automatic ctl_word_t decode_ctl(input logic [7:0] w);
        ctl_word_t c;
        c.en   = w[CTL_EN_BIT];
        c.load = w[CTL_LOAD_BIT];
        c.chan = w[CTL_CH_LSB +: CH_W];
        c.hl   = w[CTL_HL_BIT];
        return c;
    endfunction

    function automatic logic is_scan(input scan_mode_e m);
        return (m == MODE_SCAN_IRQ) || (m == MODE_SCAN);
    endfunction

endpackage

// File: rtl/adc_next_chan.sv
module adc_next_chan #(
    parameter int CW  = 3,
    localparam int NCH = 1 << CW
) (
    input  logic [CW-1:0]  cur,
    input  logic [NCH-1:0] mask,
    output logic [CW-1:0]  nxt
);
    // Walk downward so the nearest selected channel above cur is kept last.
    always_comb begin
        logic [CW-1:0] cand;
        nxt = cur;
        for (int k = NCH; k >= 1; k--) begin
            cand = cur + CW'(k);
            if (mask[cand]) nxt = cand;
        end
    end
endmodule

// File: rtl/adc_scan_flags.sv
module adc_scan_flags
    import adc_scan_pkg::*;
#(
    parameter int CW  = 3,
    localparam int NCH = 1 << CW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmpl,
    input  logic [CW-1:0]  cmpl_chan,
    input  logic [NCH-1:0] mask,
    input  scan_mode_e     mode,
    input  logic           cfg_wr,
    input  logic           data_rd,
    input  logic           status_rd,
    output logic           all_done,
    output logic           irq
);
    logic [NCH-1:0] seen_q;
    logic [NCH-1:0] seen_all;
    logic           acc_set;
    logic           irq_set;

    always_comb begin
        seen_all = seen_q | (NCH'(1) << cmpl_chan);
        acc_set  = cmpl && (|mask) && ((seen_all & mask) == mask);
        irq_set  = cmpl && ((mode == MODE_SINGLE) ||
                            (mode == MODE_SCAN_IRQ && acc_set));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q   <= '0;
            all_done <= 1'b0;
            irq      <= 1'b0;
        end else if (cfg_wr) begin
            seen_q   <= '0;
            all_done <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (acc_set)   seen_q <= '0;
            else if (cmpl) seen_q <= seen_all;
            if (acc_set)      all_done <= 1'b1;
            else if (data_rd) all_done <= 1'b0;
            if (irq_set)                   irq <= 1'b1;
            else if (status_rd || data_rd) irq <= 1'b0;
        end
    end

    // R7
    acc_mask_chk: assert property (@(posedge clk) disable iff (rst)
        all_done |-> (|mask));
    // R7
    acc_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(all_done) |-> $past(cmpl));
    // R9
    irq_mode3_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(mode) != MODE_SCAN));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int CW  = adc_scan_pkg::CH_W,
    localparam int NCH = 1 << CW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ctl_we,
    input  logic [7:0]     ctl_wdata,
    input  logic           mode_we,
    input  logic [1:0]     mode_wdata,
    input  logic           mask_we,
    input  logic [NCH-1:0] mask_wdata,
    input  logic           data_rd,
    input  logic           status_rd,
    input  logic           conv_done,
    output logic           conv_start,
    output logic [CW-1:0]  conv_chan,
    output logic           busy,
    output logic [CW-1:0]  cur_addr,
    output logic           hl_sel,
    output logic           all_done,
    output logic           irq,
    output logic           res_we,
    output logic [CW-1:0]  res_chan
);
    ctl_word_t      ctl;
    scan_mode_e     mode_q;
    logic [NCH-1:0] mask_q;
    logic           en_q;
    logic           req_q;
    logic [CW-1:0]  nxt_chan;
    logic           go;
    logic           cmpl;

    assign ctl  = decode_ctl(ctl_wdata);
    assign go   = !busy && (((mode_q == MODE_SINGLE) && req_q) ||
                            (is_scan(mode_q) && en_q && (|mask_q)));
    assign cmpl = busy && conv_done;

    adc_next_chan #(.CW(CW)) u_next (
        .cur  (conv_chan),
        .mask (mask_q),
        .nxt  (nxt_chan)
    );

    adc_scan_flags #(.CW(CW)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .cmpl      (cmpl),
        .cmpl_chan (conv_chan),
        .mask      (mask_q),
        .mode      (mode_q),
        .cfg_wr    (mode_we || mask_we),
        .data_rd   (data_rd),
        .status_rd (status_rd),
        .all_done  (all_done),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_OFF;
            mask_q     <= '0;
            en_q       <= 1'b0;
            req_q      <= 1'b0;
            hl_sel     <= 1'b0;
            cur_addr   <= '0;
            busy       <= 1'b0;
            conv_start <= 1'b0;
            conv_chan  <= '0;
            res_we     <= 1'b0;
            res_chan   <= '0;
        end else begin
            conv_start <= go;
            res_we     <= cmpl;
            if (go) begin
                busy      <= 1'b1;
                conv_chan <= cur_addr;
            end else if (cmpl) begin
                busy     <= 1'b0;
                res_chan <= conv_chan;
            end

            if (ctl_we && ctl.load) cur_addr <= ctl.chan;
            else if (cmpl)          cur_addr <= nxt_chan;

            if (mode_we)                                      req_q <= 1'b0;
            else if (ctl_we && ctl.en && mode_q == MODE_SINGLE) req_q <= 1'b1;
            else if (ctl_we && !ctl.en)                       req_q <= 1'b0;
            else if (go && mode_q == MODE_SINGLE)             req_q <= 1'b0;

            if (ctl_we) begin
                en_q   <= ctl.en;
                hl_sel <= ctl.hl;
            end
            if (mode_we) mode_q <= scan_mode_e'(mode_wdata);
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy);
    // R6
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> res_we);
    // R10
    res_idle_chk: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (!busy && !conv_start));
    // R2
    start_en_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(en_q));
endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       mode_we = 1'b0;
    logic [1:0] mode_wdata = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       data_rd = 1'b0;
    logic       status_rd = 1'b0;
    logic       conv_done = 1'b0;
    logic       conv_start, busy, hl_sel, all_done, irq, res_we;
    logic [2:0] conv_chan, cur_addr, res_chan;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int stub_cnt = 0;
    int resq[$];

    always #2.5 clk = ~clk;

    adc_scan_seq u0 (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .data_rd(data_rd), .status_rd(status_rd),
        .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
        .busy(busy), .cur_addr(cur_addr), .hl_sel(hl_sel), .all_done(all_done),
        .irq(irq), .res_we(res_we), .res_chan(res_chan)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Converter stub: done three clocks after a start pulse.
    always @(negedge clk) begin
        if (conv_start) begin
            stub_cnt = 3;
            starts++;
        end else if (stub_cnt > 0) stub_cnt--;
        conv_done = (stub_cnt == 1);
        if (res_we) resq.push_back(int'(res_chan));
    end

    // Behavioural reference model
    bit m_en, m_req, m_busy, m_start, m_rwe, m_acc, m_irq, m_hl;
    int m_cur, m_chan, m_rch, m_mode;
    bit [7:0] m_mask, m_seen;

    function automatic int next_sel(input int c, input bit [7:0] m);
        for (int k = 1; k <= 8; k++) if (m[(c + k) % 8]) return (c + k) % 8;
        return c;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_req = 0; m_busy = 0; m_start = 0; m_rwe = 0;
            m_acc = 0; m_irq = 0; m_hl = 0; m_cur = 0; m_chan = 0;
            m_rch = 0; m_mode = 0; m_mask = 0; m_seen = 0;
        end else begin
            bit go, cm, aset, iset;
            int nx;
            bit [7:0] all;
            go = !m_busy && ((m_mode == 1 && m_req) ||
                             (m_mode >= 2 && m_en && m_mask != 0));
            cm = m_busy && conv_done;
            nx = next_sel(m_chan, m_mask);
            all = m_seen | (8'b1 << m_chan);
            aset = cm && m_mask != 0 && ((all & m_mask) == m_mask);
            iset = cm && (m_mode == 1 || (m_mode == 2 && aset));
            if (mode_we || mask_we) begin
                m_seen = 0; m_acc = 0; m_irq = 0;
            end else begin
                if (aset) m_seen = 0; else if (cm) m_seen = all;
                if (aset) m_acc = 1; else if (data_rd) m_acc = 0;
                if (iset) m_irq = 1; else if (status_rd || data_rd) m_irq = 0;
            end
            m_start = go;
            m_rwe = cm;
            if (go) begin m_busy = 1; m_chan = m_cur; end
            else if (cm) begin m_busy = 0; m_rch = m_chan; end
            if (ctl_we && ctl_wdata[4]) m_cur = int'(ctl_wdata[3:1]);
            else if (cm) m_cur = nx;
            if (mode_we) m_req = 0;
            else if (ctl_we && ctl_wdata[7] && m_mode == 1) m_req = 1;
            else if (ctl_we && !ctl_wdata[7]) m_req = 0;
            else if (go && m_mode == 1) m_req = 0;
            if (ctl_we) begin m_en = ctl_wdata[7]; m_hl = ctl_wdata[0]; end
            if (mode_we) m_mode = int'(mode_wdata);
            if (mask_we) m_mask = mask_wdata;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(conv_start == m_start, "R2 conv_start", conv_start, m_start);
            chk(int'(conv_chan) == m_chan, "R4 conv_chan", conv_chan, m_chan);
            chk(int'(cur_addr) == m_cur, "R4 cur_addr", cur_addr, m_cur);
            chk(busy == m_busy, "R6 busy", busy, m_busy);
            chk(all_done == m_acc, "R7 all_done", all_done, m_acc);
            chk(irq == m_irq, "R9 irq", irq, m_irq);
            chk(res_we == m_rwe, "R10 res_we", res_we, m_rwe);
            chk(int'(res_chan) == m_rch, "R10 res_chan", res_chan, m_rch);
            chk(hl_sel == m_hl, "R1 hl_sel", hl_sel, m_hl);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1; ctl_wdata = v;
        tick(1);
        ctl_we = 0;
    endtask

    task automatic wr_mode(input logic [1:0] v);
        mode_we = 1; mode_wdata = v;
        tick(1);
        mode_we = 0;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        mask_we = 1; mask_wdata = v;
        tick(1);
        mask_we = 0;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        int s0, r0, c0, n, cnt3;
        tick(3);
        // R12 reset state
        chk({conv_start, busy, all_done, irq, res_we, hl_sel} == 6'b0, "R12 flags", 0, 0);
        chk(cur_addr == 3'd0 && conv_chan == 3'd0, "R12 address", cur_addr, 0);
        rst = 0;
        tick(2);

        // Scan with interrupt, mask channels 0,2,5,7, start at 2
        wr_mode(2'd2);
        wr_mask(8'hA5);
        s0 = starts;
        wr_ctl(8'h94);
        n = 0;
        while (!all_done && n < 200) begin tick(1); n++; end
        chk(starts > s0, "R2 scan started", starts, s0 + 1);
        chk(resq.size() >= 4, "R4 pass length", resq.size(), 4);
        if (resq.size() >= 4) begin
            chk(resq[0] == 2, "R4 order[0]", resq[0], 2);
            chk(resq[1] == 5, "R4 order[1]", resq[1], 5);
            chk(resq[2] == 7, "R4 order[2]", resq[2], 7);
            chk(resq[3] == 0, "R4 wrap order[3]", resq[3], 0);
        end
        chk(irq == 1'b1, "R9 mode2 end of pass", irq, 1);

        // R3 clear enable mid conversion
        n = 0;
        while (!busy && n < 20) begin tick(1); n++; end
        s0 = starts;
        r0 = resq.size();
        wr_ctl(8'h00);
        tick(20);
        chk(resq.size() == r0 + 1, "R3 in-flight completes", resq.size(), r0 + 1);
        chk(starts == s0, "R3 no further start", starts, s0);

        // R5 unmasked loaded channel, mode 3
        wr_mode(2'd3);
        resq.delete();
        wr_ctl(8'h96);
        n = 0;
        while (resq.size() < 6 && n < 300) begin tick(1); n++; end
        wr_ctl(8'h00);
        tick(20);
        cnt3 = 0;
        for (int i = 0; i < resq.size(); i++) if (resq[i] == 3) cnt3++;
        chk(cnt3 == 1, "R5 unmasked once", cnt3, 1);
        if (resq.size() >= 6) begin
            chk(resq[0] == 3, "R5 first is loaded", resq[0], 3);
            chk(resq[5] == 5, "R4 second pass", resq[5], 5);
        end
        chk(irq == 1'b0, "R9 mode3 silent", irq, 0);

        // R1 load enable
        c0 = int'(cur_addr);
        wr_ctl(8'h0C);
        tick(1);
        chk(int'(cur_addr) == c0, "R1 load low ignored", cur_addr, c0);
        wr_ctl(8'h1D);
        tick(1);
        chk(cur_addr == 3'd6, "R1 load high", cur_addr, 6);
        chk(hl_sel == 1'b1, "R1 hl bit", hl_sel, 1);

        // R8 single mode
        wr_mode(2'd1);
        wr_mask(8'h03);
        resq.delete();
        s0 = starts;
        wr_ctl(8'h90);
        tick(15);
        chk(resq.size() == 1, "R8 one conversion", resq.size(), 1);
        chk(irq == 1'b1, "R9 mode1 irq", irq, 1);
        chk(all_done == 1'b0, "R8 not all explicit", all_done, 0);
        chk(cur_addr == 3'd1, "R4 advance after single", cur_addr, 1);
        status_rd = 1; tick(1); status_rd = 0;
        tick(1);
        chk(irq == 1'b0, "R9 status read clears", irq, 0);
        wr_ctl(8'h92);
        tick(15);
        chk(resq.size() == 2 && resq[1] == 1, "R8 second channel", resq.size(), 2);
        chk(all_done == 1'b1, "R8 all explicit", all_done, 1);
        tick(20);
        chk(starts == s0 + 2, "R8 one per write", starts, s0 + 2);
        data_rd = 1; tick(1); data_rd = 0;
        tick(1);
        chk(all_done == 1'b0 && irq == 1'b0, "R7 data read clears", all_done, 0);

        // R11 empty mask and mode 0
        wr_mode(2'd2);
        wr_mask(8'h00);
        s0 = starts;
        wr_ctl(8'h90);
        tick(30);
        chk(starts == s0, "R11 empty mask", starts, s0);
        wr_mode(2'd0);
        wr_mask(8'hFF);
        wr_ctl(8'h90);
        tick(30);
        chk(starts == s0, "R11 mode off", starts, s0);
        wr_ctl(8'h00);
        tick(5);

        summary();
        $finish;
    end
endmodule